// File: doc/BRIEF.md
# Windowed DC-Offset and Tweeter-Presence Qualifier

This block serves one amplifier channel. It qualifies two slow diagnostic measurements over a window whose length the host sets. A window opens when the check's enable goes from low to high, or on a host read while the check stays enabled. It closes on the next host read, and a new window opens on that same cycle. The DC check watches a comparator level that flags an output offset beyond about two volts. The AC check watches two current sensors: a pulse input that fires each time the peak output current passes the high threshold, and a level flag that is high while the current stays under the low threshold.

On each read the block latches three result bits. The offset bit is set only if the comparator held high through the whole window. The open-tweeter bit is set only if too few high-current pulses were seen and the low-current flag held high throughout. A short-circuit protection event anywhere in an open window voids both checks. A voided window reports neither fault and raises an invalid bit instead. The analog comparators and the test tone live outside the block.

Top module: `dcac_win_qual`

## Requirements
- R1: While reset is held, and after it until the first read, ofs_det, open_tw and win_void are all 0.
- R2: With ofs_en high, if ofs_flag is high on every cycle from the cycle after the window opened up to and including the read cycle, ofs_det reads 1 after that read.
- R3: If ofs_flag is low on any single cycle of the window, including the read cycle, ofs_det reads 0 after the read.
- R4: A read starts a fresh window, so a dip of ofs_flag in one window has no effect on the result of the next window.
- R5: With ac_en high and lo_flag high for the whole window, fewer than PULSE_MIN (default 3) rising edges of hi_pulse make open_tw read 1.
- R6: PULSE_MIN or more rising edges of hi_pulse in the window make open_tw read 0. A pulse held high for several cycles counts as one edge.
- R7: If lo_flag is low on any cycle of the AC window, open_tw reads 0 whatever the pulse count.
- R8: If scp_flag is high on any cycle of an open window of either check, that read returns ofs_det=0, open_tw=0 and win_void=1. The next clean window reports win_void=0.
- R9: A check whose enable is low at the read reports 0, whatever its inputs are.
- R10: The three outputs change only on a cycle where rd_stb is high. Between reads they hold, whatever the other inputs do.
- R11: The flag levels on the cycle the enable rises and earlier are ignored. Persistence is judged from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ofs_en | input | 1 | DC offset check enable level |
| ac_en | input | 1 | AC current check enable level |
| rd_stb | input | 1 | One-cycle host read strobe; closes and reopens windows |
| ofs_flag | input | 1 | Offset comparator, high while the offset is excessive |
| hi_pulse | input | 1 | High-current detector; each rising edge is one pulse |
| lo_flag | input | 1 | Low-current flag, high while the current is below the low threshold |
| scp_flag | input | 1 | Short-circuit protection active |
| ofs_det | output | 1 | Latched excess-offset result |
| open_tw | output | 1 | Latched open-tweeter result |
| win_void | output | 1 | Latched invalid-window result |

## Verification
The offset check is tried with a comparator held high all the way through, with a single-cycle dip, and with a low level placed only before the enable rises. Together these separate true whole-window persistence from last-sample or ever-high behaviour, and show where the window starts. The tweeter check is fed two clean pulses, a long held pulse plus one short pulse, and three pulses. This separates edge counting from level counting and shows the saturating threshold. A one-cycle dip of the low-current flag shows that its stability is enforced. A one-cycle protection event in the middle of a window, followed by a clean window, shows that voiding takes priority over both faults and clears on the next read. Toggling every input between reads shows that the results hold.

// File: rtl/dcac_qual_pkg.sv
package dcac_qual_pkg;
   // index of each qualified measurement in the per-check vectors
   localparam int CHK_OFS = 0;
   localparam int CHK_AC  = 1;
   localparam int NCHK    = 2;

   typedef struct packed {
      logic ofs;
      logic tw;
      logic inv;
   } qual_res_t;
endpackage

// File: rtl/qual_win.sv
// Window sequencing for one check: opens on enable rise or on a read
// while enabled, closes (with a valid result) on a read.
module qual_win (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic rd,
   output logic open_evt,
   output logic act,
   output logic close
);
   logic act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= en;
   end

   assign act      = act_q;
   assign open_evt = en & (~act_q | rd);
   assign close    = rd & act_q & en;
endmodule

// File: rtl/qual_persist.sv
// Whole-window persistence of a level: ok is high only if flag was high
// on every active cycle since the last clr, including the present one.
module qual_persist (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic act,
   input  logic flag,
   output logic ok
);
   logic held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   held_q <= 1'b0;
      else if (clr) held_q <= 1'b1;
      else if (act) held_q <= held_q & flag;
   end

   assign ok = held_q & flag;
endmodule

// File: rtl/qual_pulse_cnt.sv
// Saturating pulse counter. EDGE=1 counts rising edges, EDGE=0 counts
// high cycles. hit includes the present cycle's pulse.
module qual_pulse_cnt #(
   parameter int MIN  = 3,
   parameter bit EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic act,
   input  logic pin,
   output logic hit
);
   localparam int W = (MIN < 2) ? 1 : $clog2(MIN + 1);
   localparam logic [W-1:0] LIM = W'(MIN);

   logic          inc;
   logic [W-1:0]  cnt_q;
   logic [W-1:0]  cnt_nx;

   generate
      if (EDGE) begin : g_edge
         logic pin_d;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin_d <= 1'b0;
            else        pin_d <= pin;
         end
         assign inc = pin & ~pin_d;
      end else begin : g_level
         assign inc = pin;
      end
   endgenerate

   always_comb begin
      cnt_nx = cnt_q;
      if (act && inc && (cnt_q != LIM)) cnt_nx = cnt_q + W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_nx;
   end

   assign hit = (cnt_nx == LIM);
endmodule

// File: rtl/dcac_win_qual.sv
module dcac_win_qual
   import dcac_qual_pkg::*;
#(
   parameter int PULSE_MIN  = 3,
   parameter bit PULSE_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ofs_en,
   input  logic ac_en,
   input  logic rd_stb,
   input  logic ofs_flag,
   input  logic hi_pulse,
   input  logic lo_flag,
   input  logic scp_flag,
   output logic ofs_det,
   output logic open_tw,
   output logic win_void
);
   generate
      if (PULSE_MIN < 1 || PULSE_MIN > 255) begin : g_bad_min
         $error("dcac_win_qual: PULSE_MIN out of range");
      end
   endgenerate

   logic [NCHK-1:0] en_v, open_v, act_v, close_v, clean_v;
   logic            ofs_ok, lo_ok, tw_hit, void_any;
   qual_res_t       res_nx, res_q;

   assign en_v[CHK_OFS] = ofs_en;
   assign en_v[CHK_AC]  = ac_en;

   generate
      for (genvar i = 0; i < NCHK; i++) begin : g_chk
         qual_win u_win (
            .clk(clk), .rst_n(rst_n), .en(en_v[i]), .rd(rd_stb),
            .open_evt(open_v[i]), .act(act_v[i]), .close(close_v[i]));
         // protection-free tracker, one per window
         qual_persist u_clean (
            .clk(clk), .rst_n(rst_n), .clr(open_v[i]), .act(act_v[i]),
            .flag(~scp_flag), .ok(clean_v[i]));
      end
   endgenerate

   qual_persist u_ofs (
      .clk(clk), .rst_n(rst_n), .clr(open_v[CHK_OFS]), .act(act_v[CHK_OFS]),
      .flag(ofs_flag), .ok(ofs_ok));

   qual_persist u_lo (
      .clk(clk), .rst_n(rst_n), .clr(open_v[CHK_AC]), .act(act_v[CHK_AC]),
      .flag(lo_flag), .ok(lo_ok));

   qual_pulse_cnt #(.MIN(PULSE_MIN), .EDGE(PULSE_EDGE)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(open_v[CHK_AC]), .act(act_v[CHK_AC]),
      .pin(hi_pulse), .hit(tw_hit));

   assign void_any = |(close_v & ~clean_v);

   always_comb begin
      res_nx.inv = void_any;
      res_nx.ofs = close_v[CHK_OFS] & ofs_ok & ~void_any;
      res_nx.tw  = close_v[CHK_AC] & lo_ok & ~tw_hit & ~void_any;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      res_q <= '0;
      else if (rd_stb) res_q <= res_nx;
   end

   assign ofs_det  = res_q.ofs;
   assign open_tw  = res_q.tw;
   assign win_void = res_q.inv;
endmodule

// File: rtl/dcac_win_qual_chk.sv
module dcac_win_qual_chk (
   input logic clk,
   input logic rst_n,
   input logic ofs_en,
   input logic ac_en,
   input logic rd_stb,
   input logic ofs_flag,
   input logic lo_flag,
   input logic ofs_det,
   input logic open_tw,
   input logic win_void
);
   // R10: results move only on a read
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable({ofs_det, open_tw, win_void}));

   // R8: a void window reports no fault
   a_r8_void_excl: assert property (@(posedge clk) disable iff (!rst_n)
      win_void |-> (!ofs_det && !open_tw));

   // R3: comparator low at the closing read forbids an offset report
   a_r3_dip: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !ofs_flag) |=> !ofs_det);

   // R7: low-current flag low at the closing read forbids open-tweeter
   a_r7_lo_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !lo_flag) |=> !open_tw);

   // R9: disabled checks report nothing
   a_r9_off_ofs: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !ofs_en) |=> !ofs_det);

   a_r9_off_ac: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !ac_en) |=> !open_tw);
endmodule

bind dcac_win_qual dcac_win_qual_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ofs_en(ofs_en), .ac_en(ac_en),
   .rd_stb(rd_stb), .ofs_flag(ofs_flag), .lo_flag(lo_flag),
   .ofs_det(ofs_det), .open_tw(open_tw), .win_void(win_void));

// File: tb/sim_dcac_win_qual.sv
module sim_dcac_win_qual;
   localparam int CLK_PER = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ofs_en = 0, ac_en = 0, rd_stb = 0;
   logic ofs_flag = 0, hi_pulse = 0, lo_flag = 0, scp_flag = 0;
   logic ofs_det, open_tw, win_void;

   int total = 0;
   int bad = 0;
   logic [2:0] exp_q[$];
   string      tag_q[$];
   logic [2:0] last_exp = 3'b000;

   always #(CLK_PER/2) clk = ~clk;

   dcac_win_qual u0 (
      .clk(clk), .rst_n(rst_n), .ofs_en(ofs_en), .ac_en(ac_en),
      .rd_stb(rd_stb), .ofs_flag(ofs_flag), .hi_pulse(hi_pulse),
      .lo_flag(lo_flag), .scp_flag(scp_flag), .ofs_det(ofs_det),
      .open_tw(open_tw), .win_void(win_void));

   task automatic cmp(input string tag, input logic [2:0] exp);
      total++;
      if ({ofs_det, open_tw, win_void} !== exp) begin
         bad++;
         $display("FAIL %s: got ofs=%0b tw=%0b inv=%0b exp ofs=%0b tw=%0b inv=%0b",
                  tag, ofs_det, open_tw, win_void, exp[2], exp[1], exp[0]);
      end
   endtask

   // monitor: pops the expected result after each read edge
   initial begin
      forever begin
         @(posedge clk);
         if (rd_stb) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
               total++; bad++;
               $display("FAIL scoreboard: read with no expected item");
            end else begin
               last_exp = exp_q.pop_front();
               cmp(tag_q.pop_front(), last_exp);
            end
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd_win(input string tag, input logic o, input logic t, input logic v);
      exp_q.push_back({o, t, v});
      tag_q.push_back(tag);
      @(negedge clk) rd_stb = 1'b1;
      @(negedge clk) rd_stb = 1'b0;
   endtask

   task automatic pulse();
      @(negedge clk) hi_pulse = 1'b1;
      @(negedge clk) hi_pulse = 1'b0;
      @(negedge clk);
   endtask

   task automatic hold_chk(input int n);
      repeat (n) begin
         @(negedge clk);
         cmp("R10 hold", last_exp);
      end
   endtask

   task automatic finish_up();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(CLK_PER * 50000);
      total++; bad++;
      $display("FAIL watchdog: run hung, got no end exp end");
      finish_up();
   end

   initial begin
      idle(3);
      cmp("R1 reset", 3'b000);
      rst_n = 1'b1;
      idle(2);
      cmp("R1 after reset", 3'b000);

      // R2: comparator high for a whole window
      @(negedge clk) begin ofs_flag = 1; ofs_en = 1; end
      idle(5);
      rd_win("R2 persistent offset", 1, 0, 0);
      // R3: one-cycle dip
      idle(2);
      @(negedge clk) ofs_flag = 0;
      @(negedge clk) ofs_flag = 1;
      idle(2);
      rd_win("R3 dip clears offset", 0, 0, 0);
      // R4: next window is clean
      idle(3);
      rd_win("R4 fresh window", 1, 0, 0);
      // R9: disabled offset check
      @(negedge clk) ofs_en = 0;
      idle(3);
      rd_win("R9 offset disabled", 0, 0, 0);
      // R11: low level before and at the enable rise is ignored
      @(negedge clk) ofs_flag = 0;
      idle(3);
      @(negedge clk) ofs_en = 1;
      @(negedge clk) ofs_flag = 1;
      idle(3);
      rd_win("R11 window starts after enable", 1, 0, 0);
      @(negedge clk) begin ofs_en = 0; ofs_flag = 0; end

      // R5: two pulses, low flag stable
      @(negedge clk) begin lo_flag = 1; ac_en = 1; end
      idle(2);
      pulse(); pulse();
      rd_win("R5 two pulses open tweeter", 0, 1, 0);
      // R6: held pulse counts once
      @(negedge clk) hi_pulse = 1;
      idle(4);
      @(negedge clk) hi_pulse = 0;
      @(negedge clk);
      pulse();
      rd_win("R6 held pulse counts once", 0, 1, 0);
      // R6: three pulses confirm the tweeter
      pulse(); pulse(); pulse();
      rd_win("R6 three pulses present", 0, 0, 0);
      // R7: low flag dip
      idle(2);
      @(negedge clk) lo_flag = 0;
      @(negedge clk) lo_flag = 1;
      idle(2);
      rd_win("R7 low flag unstable", 0, 0, 0);
      // R9: AC check disabled
      @(negedge clk) ac_en = 0;
      idle(3);
      rd_win("R9 ac disabled", 0, 0, 0);
      @(negedge clk) ac_en = 1;
      idle(2);
      rd_win("R5 reopened ac window", 0, 1, 0);

      // R8: protection event voids both checks
      @(negedge clk) begin ofs_en = 1; ofs_flag = 1; end
      idle(2);
      @(negedge clk) scp_flag = 1;
      @(negedge clk) scp_flag = 0;
      idle(2);
      rd_win("R8 void window", 0, 0, 1);
      idle(3);
      rd_win("R8 clean window after void", 1, 1, 0);

      // R10: outputs hold while inputs move between reads
      fork
         hold_chk(8);
         begin
            @(negedge clk) ofs_flag = 0;
            @(negedge clk) scp_flag = 1;
            @(negedge clk) begin scp_flag = 0; hi_pulse = 1; lo_flag = 0; end
            @(negedge clk) begin hi_pulse = 0; ofs_en = 0; end
         end
      join
      idle(2);
      finish_up();
   end
endmodule